// File: doc/BRIEF.md
# Spike-Excising Greatest-Of CFAR Detector

This block decides, one range cell at a time, whether a pulsed-radar return stands out from the surrounding clutter. Range samples arrive one per time-base enable (`tick`). The block keeps a short history of recent samples. The cell under test sits in the middle of that history. Guard cells on each side of it cover the spread of the transmitted pulse, and beyond the guard cells lie a leading and a trailing reference window of eight cells each.

For each window the block forms the sum of the cells and finds the largest cell at the same moment. It then subtracts that largest cell, which removes a single interfering target or clutter spike without any sorting. The larger of the two cleaned sums is the noise estimate. That estimate is scaled by a programmable factor and compared with the cell under test.

A period trigger from the receiver starts every pulse repetition interval. The trigger empties the history so that no sample from the previous period can reach a window. It also latches the guard width and the scale factor. The guard width is derived from a pulse-duration input. Detections are reported with a fixed latency, together with a valid strobe and the level of the cell under test.

Top module: `spike_go_cfar`

## Requirements
- R1: While reset is low and just after it, `det_valid`, `det` and `cut_level` are 0. The history, the fill count, the guard width and the scale factor are all cleared.
- R2: Each reference window is eight cells. Its cleaned value is the window sum minus one copy of the largest cell in that window.
- R3: The noise estimate is the larger of the two cleaned window values.
- R4: `det` is 1 exactly when cut × 7 × 16 > estimate × scale. The comparison is strict, so a cell that lands exactly on the threshold gives 0.
- R5: On a trigger, the guard width G is latched as ceil(`pulse_dur` / 4), where `pulse_dur` is in quarter-sample units. With C = 12, the cell under test is the sample taken 12 ticks before the newest one. The leading window holds the samples taken G+1 to G+8 ticks after it, and the trailing window holds those taken G+1 to G+8 ticks before it. `pulse_dur` has no effect between triggers.
- R6: A trigger empties the history. A tick in the same cycle as the trigger supplies the first sample of the new period. `det_valid` stays 0 until at least 21+G samples have arrived since the trigger.
- R7: A tick sampled at clock edge k produces its result right after edge k+2. In that cycle `det_valid` is high for one clock, and `cut_level` holds the sample taken 12 ticks before the sample at edge k.
- R8: The 8-bit scale factor has 4 fractional bits. It is latched on a trigger and has no effect between triggers.
- R9: A cycle without a tick does not move the history and produces no `det_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base enable, one range sample per assertion |
| frame_start | input | 1 | Period trigger; empties the history and latches settings |
| sample | input | 8 | Range sample magnitude |
| pulse_dur | input | 4 | Pulse duration in quarter-sample units |
| scale | input | 8 | Threshold factor, 4 fractional bits |
| det_valid | output | 1 | One-clock strobe: a cell-under-test decision is present |
| det | output | 1 | Detection flag, meaningful with det_valid |
| cut_level | output | 8 | Level of the cell under test for this decision |

## Verification
The bench first places spikes inside one window. A design that dropped the excision, or removed the wrong cell, would flag too few cells next to the spikes. Across a step in the clutter level, a design that took the smaller or the mean of the two windows would give spurious detections at the edge. A flat stream with cells one count above the flat level probes the strict threshold: a design using greater-or-equal would flag every flat cell. The bench also issues triggers while old, large samples are still in the history, inserts gaps between ticks, and changes the scale and pulse duration in the middle of a period. These cases expose a design that leaks old samples into a window, opens `det_valid` early, shifts on idle cycles, or applies settings before the next trigger.

// File: rtl/cfar_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the CFAR detector: integer arithmetic used to size
// the datapath from the top-level parameters. Assumes non-negative args.
package cfar_pkg;
    // ceil(num / 2**shift) for non-negative num
    function automatic int ceil_pow2_div(input int num, input int shift);
        return (num + (1 << shift) - 1) >> shift;
    endfunction

    // larger of two integers, used for width sizing
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/cfar_range_line.sv
`timescale 1ns/1ps
// Range history for the CFAR detector. Holds the last L samples (index 0
// newest), counts samples since the period trigger, and latches the guard
// width and scale factor on the trigger. Assumes at most one sample per clock.
module cfar_range_line #(
    parameter int W    = 8,
    parameter int N    = 8,
    parameter int MAXG = 4,
    parameter int L    = 25,
    parameter int C    = 12,
    parameter int GW   = 3,
    parameter int PDW  = 4,
    parameter int PDF  = 2,
    parameter int SW   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  frame_start,
    input  logic [W-1:0]          sample,
    input  logic [PDW-1:0]        pulse_dur,
    input  logic [SW-1:0]         scale_in,
    output logic [L-1:0][W-1:0]   line,
    output logic                  line_vld,
    output logic                  ready,
    output logic [GW-1:0]         guard,
    output logic [SW-1:0]         scale_q
);
    localparam int CW = $clog2(L + 1);
    localparam logic [CW-1:0] FILL_MAX = CW'(L);

    logic [CW-1:0] fill;
    logic [PDW:0]  dur_up;
    logic [GW-1:0] guard_new;

    // round the pulse duration up to whole samples
    always_comb begin
        dur_up    = {1'b0, pulse_dur} + (PDW+1)'((1 << PDF) - 1);
        guard_new = GW'(dur_up >> PDF);
    end

    // both windows are filled by the current period
    always_comb ready = (int'(fill) >= C + int'(guard) + N + 1);

    // history shift, fill count and per-period setting latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line     <= '0;
            fill     <= '0;
            guard    <= '0;
            scale_q  <= '0;
            line_vld <= 1'b0;
        end else begin
            line_vld <= tick;
            if (frame_start) begin
                guard   <= guard_new;
                scale_q <= scale_in;
            end
            if (frame_start && tick) begin
                line <= {{((L-1)*W){1'b0}}, sample};
                fill <= CW'(1);
            end else if (frame_start) begin
                line <= '0;
                fill <= '0;
            end else if (tick) begin
                line <= {line[L-2:0], sample};
                if (fill != FILL_MAX) fill <= fill + CW'(1);
            end
        end
    end

    // R6
    trig_clears_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (fill <= CW'(1)));
    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_MAX);
    // R5
    guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(guard));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !frame_start) |=> $stable(line));
endmodule

// File: rtl/cfar_window.sv
`timescale 1ns/1ps
// One reference window: selects N cells beyond the guard on one side of
// the cell under test, sums them and finds their peak in parallel, and
// returns sum minus peak. Purely combinational; the guard is assumed <= MAXG.
module cfar_window #(
    parameter int W    = 8,
    parameter int N    = 8,
    parameter int L    = 25,
    parameter int C    = 12,
    parameter int GW   = 3,
    parameter int SUMW = 12,
    parameter bit LEAD = 1'b1
) (
    input  logic [L-1:0][W-1:0] line,
    input  logic [GW-1:0]       guard,
    output logic [SUMW-1:0]     clean
);
    localparam int IW = $clog2(L);

    logic [N-1:0][W-1:0] cells;
    logic [SUMW-1:0]     total;
    logic [W-1:0]        peak;

    // tap selection: newer side counts down from the CUT, older side up
    for (genvar k = 0; k < N; k++) begin : g_tap
        if (LEAD) begin : g_lead
            assign cells[k] = line[IW'(C - 1 - k) - IW'(guard)];
        end else begin : g_trail
            assign cells[k] = line[IW'(C + 1 + k) + IW'(guard)];
        end
    end

    // sum and peak found in the same pass, no ordering of cells
    always_comb begin
        total = '0;
        peak  = '0;
        for (int k = 0; k < N; k++) begin
            total = total + SUMW'(cells[k]);
            if (cells[k] > peak) peak = cells[k];
        end
        clean = total - SUMW'(peak);
    end
endmodule

// File: rtl/cfar_decide.sv
`timescale 1ns/1ps
// Decision pipeline: stage 1 registers the greatest-of estimate with the
// CUT and scale; stage 2 compares CUT*(N-1)*2**SF against estimate*scale.
// Assumes inputs are consistent in the cycle ok_in is sampled.
module cfar_decide #(
    parameter int W    = 8,
    parameter int N    = 8,
    parameter int SUMW = 12,
    parameter int SW   = 8,
    parameter int SF   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ok_in,
    input  logic [SUMW-1:0] lead_clean,
    input  logic [SUMW-1:0] trail_clean,
    input  logic [W-1:0]    cut_in,
    input  logic [SW-1:0]   scale_in,
    output logic            det_valid,
    output logic            det,
    output logic [W-1:0]    cut_out
);
    localparam int PW   = SUMW + SW;
    localparam int LW   = W + $clog2(N) + SF;
    localparam int CMPW = cfar_pkg::max_int(PW, LW) + 1;

    logic            ok1;
    logic [SUMW-1:0] go1;
    logic [W-1:0]    cut1;
    logic [SW-1:0]   scale1;
    logic [CMPW-1:0] lhs, rhs;

    // stage 1: pick the greater window estimate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok1    <= 1'b0;
            go1    <= '0;
            cut1   <= '0;
            scale1 <= '0;
        end else begin
            ok1    <= ok_in;
            go1    <= (lead_clean > trail_clean) ? lead_clean : trail_clean;
            cut1   <= cut_in;
            scale1 <= scale_in;
        end
    end

    // scaled sides of the threshold comparison, both in whole units
    always_comb begin
        lhs = (CMPW'(cut1) * CMPW'(N - 1)) << SF;
        rhs = CMPW'(go1) * CMPW'(scale1);
    end

    // stage 2: strict compare and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_valid <= 1'b0;
            det       <= 1'b0;
            cut_out   <= '0;
        end else begin
            det_valid <= ok1;
            det       <= ok1 && (lhs > rhs);
            cut_out   <= cut1;
        end
    end

    // R7
    det_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det |-> det_valid);
    // R7
    valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> $past(ok_in, 2));
    // R3
    go_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok1 |-> (go1 >= $past(lead_clean) && go1 >= $past(trail_clean)));
endmodule

// File: rtl/spike_go_cfar.sv
`timescale 1ns/1ps
// Spike-excising greatest-of CFAR detector, top level. Sizes the history
// from the parameters, builds the two reference windows with a generate
// loop and feeds the decision pipeline. Assumes one sample per tick and a
// trigger at the start of every period.
module spike_go_cfar #(
    parameter int W   = 8,
    parameter int N   = 8,
    parameter int PDW = 4,
    parameter int PDF = 2,
    parameter int SW  = 8,
    parameter int SF  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           frame_start,
    input  logic [W-1:0]   sample,
    input  logic [PDW-1:0] pulse_dur,
    input  logic [SW-1:0]  scale,
    output logic           det_valid,
    output logic           det,
    output logic [W-1:0]   cut_level
);
    localparam int MAXG = cfar_pkg::ceil_pow2_div((1 << PDW) - 1, PDF);
    localparam int L    = 2 * N + 2 * MAXG + 1;
    localparam int C    = N + MAXG;
    localparam int GW   = $clog2(MAXG + 1);
    localparam int SUMW = W + $clog2(N + 1);

    logic [L-1:0][W-1:0] line;
    logic                line_vld, ready;
    logic [GW-1:0]       guard;
    logic [SW-1:0]       scale_q;
    logic [1:0][SUMW-1:0] clean;

    cfar_range_line #(
        .W(W), .N(N), .MAXG(MAXG), .L(L), .C(C), .GW(GW),
        .PDW(PDW), .PDF(PDF), .SW(SW)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .tick(tick), .frame_start(frame_start),
        .sample(sample), .pulse_dur(pulse_dur), .scale_in(scale),
        .line(line), .line_vld(line_vld), .ready(ready),
        .guard(guard), .scale_q(scale_q)
    );

    // index 0 is the leading (newer) side, index 1 the trailing side
    for (genvar s = 0; s < 2; s++) begin : g_win
        cfar_window #(
            .W(W), .N(N), .L(L), .C(C), .GW(GW), .SUMW(SUMW),
            .LEAD(s == 0)
        ) u_win (
            .line(line), .guard(guard), .clean(clean[s])
        );
    end

    cfar_decide #(
        .W(W), .N(N), .SUMW(SUMW), .SW(SW), .SF(SF)
    ) u_decide (
        .clk(clk), .rst_n(rst_n), .ok_in(line_vld && ready),
        .lead_clean(clean[0]), .trail_clean(clean[1]),
        .cut_in(line[C]), .scale_in(scale_q),
        .det_valid(det_valid), .det(det), .cut_out(cut_level)
    );
endmodule

// File: tb/tb_spike_go_cfar.sv
`timescale 1ns/1ps
module tb_spike_go_cfar;
    localparam int N = 8, MAXG = 4, C = N + MAXG, L = 2 * N + 2 * MAXG + 1;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, frame_start = 1'b0;
    logic [7:0] sample = '0, scale = '0;
    logic [3:0] pulse_dur = '0;
    logic       det_valid, det;
    logic [7:0] cut_level;

    spike_go_cfar dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .frame_start(frame_start),
        .sample(sample), .pulse_dur(pulse_dur), .scale(scale),
        .det_valid(det_valid), .det(det), .cut_level(cut_level)
    );

    always #2 clk = ~clk;

    int    checks = 0, errors = 0;
    bit    done = 1'b0;
    int    m_line[L];
    int    m_cnt = 0, m_g = 0, m_sc = 0;
    int    qv[$], qd[$], qc[$];
    string vtag = "R6", dtag = "R4";
    int    seed = 12345;

    function automatic int rnd(input int lo, input int span);
        seed = seed * 1103515245 + 12345;
        return lo + (((seed >> 16) & 32'h7fff) % span);
    endfunction

    task automatic check_out();
        int ev, ed, ec;
        ev = qv.pop_front(); ed = qd.pop_front(); ec = qc.pop_front();
        checks++;
        if (det_valid !== ev[0]) begin
            errors++;
            $display("FAIL %s det_valid got %0b expected %0d", vtag, det_valid, ev);
        end
        checks++;
        if (det !== ed[0]) begin
            errors++;
            $display("FAIL %s det got %0b expected %0d", dtag, det, ed);
        end
        if (ev != 0) begin
            checks++;
            if (cut_level !== ec[7:0]) begin
                errors++;
                $display("FAIL R7 cut_level got %0d expected %0d", cut_level, ec);
            end
        end
    endtask

    // one clock: check the result due now, drive inputs, advance the model
    task automatic step(input bit tk, input bit tr, input int smp);
        int ls, lp, ts, tp, v, go, ev, ed, ec;
        @(negedge clk);
        check_out();
        tick = tk; frame_start = tr; sample = smp[7:0];
        if (tr) begin
            foreach (m_line[i]) m_line[i] = 0;
            m_cnt = 0;
            m_g   = (int'(pulse_dur) + 3) / 4;
            m_sc  = int'(scale);
        end
        ev = 0; ed = 0; ec = 0;
        if (tk) begin
            for (int i = L - 1; i > 0; i--) m_line[i] = m_line[i-1];
            m_line[0] = smp & 255;
            if (m_cnt < L) m_cnt++;
            if (m_cnt >= C + m_g + N + 1) begin
                ls = 0; lp = 0; ts = 0; tp = 0;
                for (int k = 1; k <= N; k++) begin
                    v = m_line[C - m_g - k]; ls += v; if (v > lp) lp = v;
                    v = m_line[C + m_g + k]; ts += v; if (v > tp) tp = v;
                end
                go = ((ls - lp) > (ts - tp)) ? (ls - lp) : (ts - tp);
                ec = m_line[C];
                ev = 1;
                ed = (ec * (N - 1) * 16 > go * m_sc) ? 1 : 0;
            end
        end
        qv.push_back(ev); qd.push_back(ed); qc.push_back(ec);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        checks++; if (det_valid !== 1'b0) begin errors++; $display("FAIL R1 det_valid got %0b expected 0", det_valid); end
        checks++; if (det !== 1'b0) begin errors++; $display("FAIL R1 det got %0b expected 0", det); end
        checks++; if (cut_level !== 8'd0) begin errors++; $display("FAIL R1 cut_level got %0d expected 0", cut_level); end
        rst_n = 1'b1;
        repeat (3) begin qv.push_back(0); qd.push_back(0); qc.push_back(0); end

        // R2: spikes and targets inside the windows, G = 2
        dtag = "R2"; vtag = "R6";
        pulse_dur = 4'd6; scale = 8'd48;
        step(1, 1, 25);
        for (int i = 1; i < 150; i++) begin
            if (i == 80) begin
                // R8 / R5: setting changes between triggers are ignored
                scale = 8'd200; pulse_dur = 4'd15; dtag = "R8"; vtag = "R5";
            end
            step(1, 0, (i % 17 == 0) ? 240 : (i % 29 == 0) ? 200 : rnd(20, 21));
        end

        // R3: clutter edge, G = 4
        dtag = "R3"; vtag = "R6";
        pulse_dur = 4'd15; scale = 8'd40;
        step(1, 1, 8);
        for (int i = 1; i < 130; i++)
            step(1, 0, (i < 60) ? rnd(5, 11) : ((i % 23 == 0) ? 180 : rnd(80, 31)));

        // R4: flat level, threshold hit exactly, G = 0, trigger without tick
        dtag = "R4";
        pulse_dur = 4'd0; scale = 8'd16;
        step(0, 1, 0);
        for (int i = 0; i < 120; i++)
            step(1, 0, (i % 13 == 0) ? 51 : 50);

        // R9: ticks with gaps, G = 3, ending on large samples
        dtag = "R9"; vtag = "R9";
        pulse_dur = 4'd9; scale = 8'd32;
        step(1, 1, 30);
        for (int i = 1; i < 80; i++) begin
            step(1, 0, (i > 60) ? 250 : rnd(10, 40));
            step(0, 0, 99);
            step(0, 0, 7);
        end

        // R6: trigger while the history still holds the old large samples
        dtag = "R6"; vtag = "R6";
        pulse_dur = 4'd1; scale = 8'd24;
        step(1, 1, 12);
        for (int i = 1; i < 40; i++) step(1, 0, rnd(10, 6));
        step(1, 1, 14);
        for (int i = 1; i < 60; i++) step(1, 0, (i % 19 == 0) ? 90 : rnd(10, 6));

        repeat (4) step(0, 0, 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule